// File: doc/BRIEF.md
# Linked-List DMA Channel

This block is one channel of a memory-to-memory and memory-to-peripheral DMA engine. Software places descriptors in memory. Each descriptor is four consecutive 32-bit words: byte count, source address, destination address and next-descriptor address. The address of the first descriptor goes into the next-pointer register. Software then sets the fetch request and the run bit in the control register.

The channel loads the descriptor over a word-wide read port. It then moves the data in bursts. Each burst first reads a group of words into an internal staging buffer and then writes that group out over a word-wide write port. The source address and the destination address each either increment or stay fixed. Holding the destination suits a peripheral data register.

When a descriptor finishes, a sticky completion flag is raised, and the flag can drive an interrupt line. The channel then follows the next pointer. A next pointer of zero ends the chain. A chain whose last descriptor points back to its first runs forever as a cyclic buffer. While the channel runs, software can read the live address registers to track progress. It can also pause, resume or abort the channel.

Top module: `dma_chain_ch`

## Requirements
- R1: After reset, every register reads 0, `irq` is low and neither `mrd_req` nor `mwr_req` is asserted.
- R2: When the control register (0x40) has bit 12 (run) and bit 13 (fetch request) both set, the channel reads four words starting at the address in the next-pointer register (0x30). It reads them in the order count, source, destination, next pointer, at offsets +0, +4, +8 and +12. The descriptor's address is copied into the current-pointer register (0x70), and bit 13 reads back as 0.
- R3: With both addresses incrementing, the first N bytes at the source appear at the destination, where N is the byte count. On the final word of a descriptor, `mwr_be` enables only the bytes that remain (bit k enables byte k). Registers 0x00, 0x10 and 0x20 read the live count, source and destination. When the descriptor ends, the count reads 0 and each incrementing address has advanced by 4 for every word moved. Reads and writes are never requested in the same cycle.
- R4: Control bits [3:2] set the source address mode and bits [5:4] the destination address mode. A field value of 2'b00 increments the address by 4 per word, and 2'b10 holds it fixed.
- R5: Control bits [8:6] choose the burst: 000 = 4 bytes, 001 = 8, 011 = 16, 110 = 32, 111 = 64, 101 = 128, and any other code = 4. Each burst reads ceil(min(burst, remaining)/4) words before it writes any of them.
- R6: After a descriptor ends, the channel fetches the descriptor at the next pointer if that pointer is nonzero. If the pointer is zero, the channel stops. A chain closed on itself keeps running.
- R7: Clearing bit 12 pauses the channel. The beat already in flight completes, no further requests are made and all state is kept. Setting bit 12 again resumes the transfer, and it finishes with the correct data.
- R8: Writing the control register with bit 20 set stops the channel at once. The run bit and the fetch request are cleared, and requests drop in the next cycle.
- R9: Bit 0 of the status register (0xA0) is set when a descriptor ends, including a descriptor with a zero count, which moves no data. A write with bit 0 at 0 clears the flag. A write with bit 0 at 1 leaves it unchanged.
- R10: A completion in the same cycle as a software clear leaves the status flag set.
- R11: `irq` is high exactly when status bit 0 and mask bit 0 (register 0x80) are both set.
- R12: Control bit 14 reads 1 while a fetch or a transfer is in progress and 0 when the channel is idle. No memory request is made while the channel is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mrd_req | output | 1 | Read request, held until acknowledged |
| mrd_addr | output | AW | Read word address |
| mrd_ack | input | 1 | Read acknowledge; `mrd_data` valid |
| mrd_data | input | 32 | Read data |
| mwr_req | output | 1 | Write request, held until acknowledged |
| mwr_addr | output | AW | Write word address |
| mwr_data | output | 32 | Write data |
| mwr_be | output | 4 | Write byte enables |
| mwr_ack | input | 1 | Write acknowledge |
| irq | output | 1 | Completion interrupt |

## Verification
The bench builds the block with its default parameters: 32-bit addresses and a 17-bit count. The 17-bit count holds the 64 KiB maximum. The bench places the descriptors and buffers in a 16 KiB memory model that acknowledges requests after random delays. Random counts of up to 300 bytes give multi-burst descriptors and partial final words under every burst code. Directed runs cover the hold modes, a zero-count descriptor, a two-entry cyclic chain, a pause in the middle of a transfer and an abort. One run holds the write acknowledge so that the final write lands in the same cycle as a status clear.

// File: rtl/dma_chain_ch.sv
module dma_chain_ch #(
  parameter int AW = 32,
  parameter int CW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [7:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          mrd_req,
  output logic [AW-1:0] mrd_addr,
  input  logic          mrd_ack,
  input  logic [31:0]   mrd_data,
  output logic          mwr_req,
  output logic [AW-1:0] mwr_addr,
  output logic [31:0]   mwr_data,
  output logic [3:0]    mwr_be,
  input  logic          mwr_ack,
  output logic          irq
);
  localparam int BUFW = 32;
  localparam int IW   = $clog2(BUFW);

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_SETUP, S_RD, S_WR} st_t;

  st_t           st;
  logic          act, en_q, fet_q, mask_q, sts_q;
  logic [1:0]    smode_q, dmode_q;
  logic [2:0]    bsz_q;
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] src_q, dst_q, nxt_q, cur_q;
  logic [IW:0]   idx, bw;
  logic [31:0]   buf_q [BUFW];

  function automatic logic [7:0] burst_bytes(input logic [2:0] c);
    case (c)
      3'd1:    return 8'd8;
      3'd3:    return 8'd16;
      3'd6:    return 8'd32;
      3'd7:    return 8'd64;
      3'd5:    return 8'd128;
      default: return 8'd4;
    endcase
  endfunction

  logic [CW-1:0] blen, wbytes;
  logic [IW:0]   words;
  logic          rd_hit, wr_hit, last_beat, cmp_set, busy, abort_wr, sts_clr;

  assign blen      = (cnt_q < CW'(burst_bytes(bsz_q))) ? cnt_q : CW'(burst_bytes(bsz_q));
  assign words     = (IW+1)'((blen + CW'(3)) >> 2);
  assign wbytes    = (cnt_q < CW'(4)) ? cnt_q : CW'(4);
  assign rd_hit    = act && mrd_ack;
  assign wr_hit    = act && mwr_ack;
  assign last_beat = (idx == bw - (IW+1)'(1));
  assign cmp_set   = (st == S_SETUP && cnt_q == '0) ||
                     (st == S_WR && wr_hit && last_beat && cnt_q <= CW'(4));
  assign busy      = (st != S_IDLE);
  assign abort_wr  = reg_we && reg_addr == 8'h40 && reg_wdata[20];
  assign sts_clr   = reg_we && reg_addr == 8'hA0 && !reg_wdata[0];

  assign mrd_req  = act && (st == S_FETCH || st == S_RD);
  assign mrd_addr = (st == S_FETCH) ? nxt_q + AW'({idx[1:0], 2'b00}) : src_q;
  assign mwr_req  = act && st == S_WR;
  assign mwr_addr = dst_q;
  assign mwr_data = buf_q[idx[IW-1:0]];
  assign mwr_be   = (cnt_q >= CW'(4)) ? 4'hf : 4'hf >> (3'd4 - {1'b0, cnt_q[1:0]});
  assign irq      = sts_q & mask_q;

  always_comb begin
    case (reg_addr)
      8'h00:   reg_rdata = 32'(cnt_q);
      8'h10:   reg_rdata = 32'(src_q);
      8'h20:   reg_rdata = 32'(dst_q);
      8'h30:   reg_rdata = 32'(nxt_q);
      8'h40:   reg_rdata = {17'd0, busy, fet_q, en_q, 3'd0, bsz_q, dmode_q, smode_q, 2'd0};
      8'h70:   reg_rdata = 32'(cur_q);
      8'h80:   reg_rdata = {31'd0, mask_q};
      8'hA0:   reg_rdata = {31'd0, sts_q};
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) if (st == S_RD && rd_hit) buf_q[idx[IW-1:0]] <= mrd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; act <= 1'b0; en_q <= 1'b0; fet_q <= 1'b0; mask_q <= 1'b0; sts_q <= 1'b0;
      smode_q <= '0; dmode_q <= '0; bsz_q <= '0; cnt_q <= '0;
      src_q <= '0; dst_q <= '0; nxt_q <= '0; cur_q <= '0; idx <= '0; bw <= '0;
    end else begin
      if (reg_we) begin
        case (reg_addr)
          8'h00: cnt_q <= reg_wdata[CW-1:0];
          8'h10: src_q <= AW'(reg_wdata);
          8'h20: dst_q <= AW'(reg_wdata);
          8'h30: nxt_q <= AW'(reg_wdata);
          8'h40: begin
            smode_q <= reg_wdata[3:2]; dmode_q <= reg_wdata[5:4]; bsz_q <= reg_wdata[8:6];
            en_q <= reg_wdata[12]; fet_q <= reg_wdata[13];
          end
          8'h80: mask_q <= reg_wdata[0];
          default: ;
        endcase
      end
      sts_q <= cmp_set | (sts_q & ~sts_clr);

      case (st)
        S_IDLE: if (fet_q && en_q) begin
          st <= S_FETCH; cur_q <= nxt_q; idx <= '0; fet_q <= 1'b0;
        end
        S_FETCH: if (!act) act <= en_q;
          else if (mrd_ack) begin
            act <= 1'b0;
            case (idx[1:0])
              2'd0: cnt_q <= mrd_data[CW-1:0];
              2'd1: src_q <= AW'(mrd_data);
              2'd2: dst_q <= AW'(mrd_data);
              default: nxt_q <= AW'(mrd_data);
            endcase
            idx <= idx + 1'b1;
            if (idx[1:0] == 2'd3) st <= S_SETUP;
          end
        S_SETUP: if (cnt_q == '0) begin
            if (nxt_q != '0) begin st <= S_FETCH; cur_q <= nxt_q; idx <= '0; end
            else st <= S_IDLE;
          end else begin
            bw <= words; idx <= '0; st <= S_RD;
          end
        S_RD: if (!act) act <= en_q;
          else if (mrd_ack) begin
            act <= 1'b0;
            if (!smode_q[1]) src_q <= src_q + AW'(4);
            if (last_beat) begin idx <= '0; st <= S_WR; end
            else idx <= idx + 1'b1;
          end
        S_WR: if (!act) act <= en_q;
          else if (mwr_ack) begin
            act <= 1'b0;
            if (!dmode_q[1]) dst_q <= dst_q + AW'(4);
            cnt_q <= cnt_q - wbytes;
            if (!last_beat) idx <= idx + 1'b1;
            else if (cnt_q > CW'(4)) st <= S_SETUP;
            else if (nxt_q != '0) begin st <= S_FETCH; cur_q <= nxt_q; idx <= '0; end
            else st <= S_IDLE;
          end
        default: st <= S_IDLE;
      endcase

      if (abort_wr) begin
        st <= S_IDLE; act <= 1'b0; en_q <= 1'b0; fet_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dma_chain_ch_chk.sv
module dma_chain_ch_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_we,
  input logic [7:0]    reg_addr,
  input logic [31:0]   reg_wdata,
  input logic          mrd_req,
  input logic          mrd_ack,
  input logic [AW-1:0] mrd_addr,
  input logic          mwr_req,
  input logic          irq,
  input logic          en_q,
  input logic          mask_q,
  input logic          sts_q,
  input logic          cmp_set,
  input logic          busy
);
  logic abort_wr, sts_clr;
  assign abort_wr = reg_we && reg_addr == 8'h40 && reg_wdata[20];
  assign sts_clr  = reg_we && reg_addr == 8'hA0 && !reg_wdata[0];

  AST_PORT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mrd_req && mwr_req)); // R3
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mrd_req && !mrd_ack && !abort_wr |=> mrd_req && $stable(mrd_addr)); // R7
  AST_PAUSE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q && !mrd_req && !mwr_req |=> !mrd_req && !mwr_req); // R7
  AST_ABORT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    abort_wr |=> !busy && !mrd_req && !mwr_req); // R8
  AST_DONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_set |=> sts_q); // R9
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_set && sts_clr |=> sts_q); // R10
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> mask_q); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mrd_req && !mwr_req); // R12
endmodule

bind dma_chain_ch dma_chain_ch_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .mrd_req(mrd_req), .mrd_ack(mrd_ack), .mrd_addr(mrd_addr), .mwr_req(mwr_req), .irq(irq),
  .en_q(en_q), .mask_q(mask_q), .sts_q(sts_q), .cmp_set(cmp_set), .busy(busy)
);

// File: tb/sim_dma_chain_ch.sv
module sim_dma_chain_ch;
  logic clk = 1'b0;
  always #2 clk = ~clk;
  logic rst_n = 1'b0;

  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mrd_req, mwr_req, irq;
  logic [31:0] mrd_addr, mwr_addr, mwr_data;
  logic        mrd_ack = 1'b0;
  logic [31:0] mrd_data = '0;
  logic [3:0]  mwr_be;
  logic        mwr_ack_r = 1'b0, man_ack = 1'b0;
  logic        mwr_ack;
  assign mwr_ack = mwr_ack_r | man_ack;

  dma_chain_ch u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mrd_req(mrd_req), .mrd_addr(mrd_addr), .mrd_ack(mrd_ack),
    .mrd_data(mrd_data), .mwr_req(mwr_req), .mwr_addr(mwr_addr), .mwr_data(mwr_data),
    .mwr_be(mwr_be), .mwr_ack(mwr_ack), .irq(irq)
  );

  logic [31:0] mem [0:4095];
  int nchk = 0, nerr = 0;
  int nrd = 0, nwr = 0, rd_run = 0, first_run = -1;
  bit hold_wr = 1'b0;

  function automatic logic [31:0] pat(input logic [31:0] a);
    return ((a >> 2) * 32'h9E3779B1) ^ 32'h0F1E2D3C;
  endfunction
  function automatic logic [7:0] sbyte(input logic [31:0] a);
    return 8'(pat(a) >> (8 * a[1:0]));
  endfunction
  function automatic logic [7:0] mbyte(input logic [31:0] a);
    return 8'(mem[a[13:2]] >> (8 * a[1:0]));
  endfunction
  function automatic int burst_of(input int code);
    case (code)
      1: return 8; 3: return 16; 6: return 32; 7: return 64; 5: return 128;
      default: return 4;
    endcase
  endfunction

  always @(negedge clk) begin
    mrd_ack = 1'b0;
    mwr_ack_r = 1'b0;
    if (mrd_req && ($urandom % 3 != 0)) begin
      mrd_ack = 1'b1; mrd_data = mem[mrd_addr[13:2]]; nrd++; rd_run++;
    end
    if (mwr_req && !hold_wr && ($urandom % 3 != 0)) begin
      mwr_ack_r = 1'b1;
      for (int b = 0; b < 4; b++)
        if (mwr_be[b]) mem[mwr_addr[13:2]][8*b +: 8] = mwr_data[8*b +: 8];
      nwr++;
      if (first_run < 0) first_run = rd_run;
      rd_run = 0;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk); reg_addr = a; #1 v = reg_rdata;
  endtask

  task automatic wait_idle(input string tag);
    logic [31:0] v;
    int n = 0;
    do begin rd(8'h40, v); n++; end while (v[14] && n < 20000);
    chk({tag, " idle reached"}, 32'(v[14]), 32'd0);
  endtask

  task automatic fill_dst(input logic [31:0] d, input int n);
    for (int w = int'(d >> 2); w <= int'((d + 32'(n) + 11) >> 2); w++) mem[w] = 32'hEEEEEEEE;
  endtask

  task automatic check_copy(input string tag, input logic [31:0] s, input logic [31:0] d, input int n);
    int bad = 0;
    for (int i = 0; i < n + 8; i++) begin
      logic [7:0] e;
      e = (i < n) ? sbyte(s + 32'(i)) : 8'hEE;
      if (mbyte(d + 32'(i)) !== e) bad++;
    end
    chk(tag, 32'(bad), 32'd0);
  endtask

  task automatic put_desc(input logic [31:0] da, input int cnt, input logic [31:0] s,
                          input logic [31:0] d, input logic [31:0] nx);
    mem[da[13:2]] = 32'(cnt); mem[da[13:2] + 1] = s; mem[da[13:2] + 2] = d; mem[da[13:2] + 3] = nx;
  endtask

  task automatic start(input logic [31:0] da, input logic [31:0] base);
    wr(8'hA0, 32'd0);
    nrd = 0; nwr = 0; rd_run = 0; first_run = -1;
    wr(8'h30, da);
    wr(8'h40, base | 32'h3000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL R6 watchdog: got hang expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    logic [31:0] v, v2;
    int a0, n;
    void'($urandom(32'd7));
    for (int w = 0; w < 4096; w++) mem[w] = (w >= 1024 && w < 2048) ? pat(32'(w) * 4) : 32'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    begin
      logic [7:0] regs [8];
      regs = '{8'h00, 8'h10, 8'h20, 8'h30, 8'h40, 8'h70, 8'h80, 8'hA0};
      for (int i = 0; i < 8; i++) begin rd(regs[i], v); chk("R1 register after reset", v, 32'd0); end
    end
    chk("R1 irq after reset", 32'(irq), 32'd0);
    chk("R1 requests after reset", 32'({mrd_req, mwr_req}), 32'd0);

    wr(8'h80, 32'd1);

    // R2 R3 R5 single descriptor, 32-byte bursts
    fill_dst(32'h2000, 40);
    put_desc(32'h100, 40, 32'h1000, 32'h2000, 32'h0);
    start(32'h100, 32'(6 << 6));
    wait_idle("R6 single");
    check_copy("R3 copy 40 bytes", 32'h1000, 32'h2000, 40);
    chk("R5 reads before first write (fetch 4 + burst 8)", 32'(first_run), 32'd12);
    rd(8'h00, v); chk("R3 count at end", v, 32'd0);
    rd(8'h10, v); chk("R3 source advanced", v, 32'h1028);
    rd(8'h20, v); chk("R4 destination advanced", v, 32'h2028);
    rd(8'h70, v); chk("R2 current pointer", v, 32'h100);
    rd(8'h40, v); chk("R2 fetch bit cleared", 32'(v[13]), 32'd0);
    chk("R12 active bit clear when idle", 32'(v[14]), 32'd0);
    chk("R11 irq with mask set", 32'(irq), 32'd1);
    wr(8'h80, 32'd0); #1 chk("R11 irq masked", 32'(irq), 32'd0);
    wr(8'h80, 32'd1);
    wr(8'hA0, 32'd1); rd(8'hA0, v); chk("R9 write of one keeps flag", v, 32'd1);
    wr(8'hA0, 32'd0); rd(8'hA0, v); chk("R9 write of zero clears flag", v, 32'd0);
    chk("R11 irq drops with flag", 32'(irq), 32'd0);

    // R3 partial final word
    fill_dst(32'h2080, 10);
    put_desc(32'h110, 10, 32'h1080, 32'h2080, 32'h0);
    start(32'h110, 32'd0);
    wait_idle("R3 partial");
    check_copy("R3 partial word byte enables", 32'h1080, 32'h2080, 10);
    rd(8'h10, v); chk("R3 source advanced per word", v, 32'h108C);

    // R4 destination hold
    fill_dst(32'h2100, 12);
    put_desc(32'h120, 12, 32'h1100, 32'h2100, 32'h0);
    start(32'h120, 32'((3 << 6) | (2 << 4)));
    wait_idle("R4 dst hold");
    chk("R4 held destination has last word", mem[32'h2100 >> 2], pat(32'h1108));
    chk("R4 next destination word untouched", mem[32'h2104 >> 2], 32'hEEEEEEEE);
    rd(8'h20, v); chk("R4 destination register held", v, 32'h2100);

    // R4 source hold
    fill_dst(32'h2200, 12);
    put_desc(32'h130, 12, 32'h1200, 32'h2200, 32'h0);
    start(32'h130, 32'((1 << 6) | (2 << 2)));
    wait_idle("R4 src hold");
    n = 0;
    for (int i = 0; i < 3; i++) if (mem[(32'h2200 >> 2) + i] !== pat(32'h1200)) n++;
    chk("R4 held source repeated", 32'(n), 32'd0);
    rd(8'h10, v); chk("R4 source register held", v, 32'h1200);

    // R6 two-entry chain
    fill_dst(32'h2300, 20); fill_dst(32'h2400, 36);
    put_desc(32'h140, 20, 32'h1300, 32'h2300, 32'h180);
    put_desc(32'h180, 36, 32'h1400, 32'h2400, 32'h0);
    start(32'h140, 32'(3 << 6));
    wait_idle("R6 chain");
    check_copy("R6 chain first", 32'h1300, 32'h2300, 20);
    check_copy("R6 chain second", 32'h1400, 32'h2400, 36);
    rd(8'h70, v); chk("R6 current pointer follows chain", v, 32'h180);

    // R9 zero-count descriptor
    put_desc(32'h1C0, 0, 32'h1000, 32'h2000, 32'h0);
    start(32'h1C0, 32'd0);
    wait_idle("R9 zero count");
    chk("R9 zero count reads only descriptor", 32'(nrd), 32'd4);
    chk("R9 zero count writes nothing", 32'(nwr), 32'd0);
    rd(8'hA0, v); chk("R9 zero count sets flag", v, 32'd1);

    // R7 pause and resume
    fill_dst(32'h2500, 400);
    put_desc(32'h1D0, 400, 32'h1500, 32'h2500, 32'h0);
    start(32'h1D0, 32'd0);
    repeat (40) @(negedge clk);
    wr(8'h40, 32'd0);
    repeat (10) @(negedge clk);
    a0 = nrd + nwr;
    rd(8'h00, v);
    repeat (60) @(negedge clk);
    chk("R7 no traffic while paused", 32'(nrd + nwr), 32'(a0));
    rd(8'h00, v2); chk("R7 count kept while paused", v2, v);
    rd(8'h40, v); chk("R7 still active while paused", 32'(v[14]), 32'd1);
    wr(8'h40, 32'h1000);
    wait_idle("R7 resume");
    check_copy("R7 data after resume", 32'h1500, 32'h2500, 400);

    // R6 cyclic chain, then R8 abort
    put_desc(32'h200, 8, 32'h1600, 32'h2600, 32'h210);
    put_desc(32'h210, 8, 32'h1700, 32'h2700, 32'h200);
    fill_dst(32'h2600, 8); fill_dst(32'h2700, 8);
    start(32'h200, 32'd0);
    n = 0;
    for (int k = 0; k < 5; k++) begin
      int t = 0;
      while (!irq && t < 5000) begin @(negedge clk); t++; end
      if (irq) n++;
      wr(8'hA0, 32'd0);
    end
    chk("R6 cyclic completions", 32'(n), 32'd5);
    rd(8'h40, v); chk("R6 cyclic still running", 32'(v[14]), 32'd1);
    wr(8'h40, 32'h0010_0000);
    rd(8'h40, v);
    chk("R8 abort stops channel", 32'(v[14]), 32'd0);
    chk("R8 abort clears run bit", 32'(v[12]), 32'd0);
    n = 0;
    repeat (30) begin @(negedge clk); if (mrd_req || mwr_req) n++; end
    chk("R8 no requests after abort", 32'(n), 32'd0);
    check_copy("R6 cyclic data", 32'h1600, 32'h2600, 8);

    // R10 completion coincides with software clear
    hold_wr = 1'b1;
    put_desc(32'h240, 4, 32'h1800, 32'h2800, 32'h0);
    start(32'h240, 32'd0);
    n = 0;
    do begin @(negedge clk); n++; end while (!mwr_req && n < 1000);
    man_ack = 1'b1; reg_we = 1'b1; reg_addr = 8'hA0; reg_wdata = 32'd0;
    @(negedge clk);
    man_ack = 1'b0; reg_we = 1'b0; hold_wr = 1'b0;
    rd(8'hA0, v); chk("R10 set wins over clear", v, 32'd1);

    // R3 R5 random descriptors
    for (int it = 0; it < 8; it++) begin
      int cnt, code, bb, exp_first;
      logic [31:0] s, d;
      int codes [6];
      codes = '{0, 1, 3, 6, 7, 5};
      cnt = 1 + int'($urandom % 300);
      code = codes[$urandom % 6];
      s = 32'h1000 + ($urandom % 64) * 4;
      d = 32'h2000 + ($urandom % 64) * 16;
      bb = burst_of(code);
      exp_first = 4 + (((cnt < bb) ? cnt : bb) + 3) / 4;
      fill_dst(d, cnt);
      put_desc(32'h300, cnt, s, d, 32'h0);
      start(32'h300, 32'(code << 6));
      wait_idle("R3 random");
      check_copy("R3 random copy", s, d, cnt);
      chk("R5 random burst grouping", 32'(first_run), 32'(exp_first));
    end

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule